// File: doc/BRIEF.md
# Multi-Channel Timer Capture Unit

This block takes snapshots of a free-running 16-bit timer into five capture registers. Each channel can be set to one of two trigger sources. In pin mode, a qualified transition on the channel's input pin causes the capture. In software mode, a bus write to the channel's low byte causes the capture. Each channel has its own mode bit, so any mix of the two modes can run at the same time.

Input sampling, edge detection and latching move forward only on clock cycles where the machine-cycle strobe is high. Channels 1 to 3 react to rising edges only. Channels 0 and 4 each have a polarity input. A transition that is recognized in one machine cycle loads the timer value in the next machine cycle. In pin mode it also raises that channel's interrupt request flag. Software reads the captured values one byte at a time and clears flags by writing zeros to a flag address.

Top module: `cap_unit`

## Requirements
- R1: After reset, every capture register reads 0 and every interrupt flag is 0.
- R2: Read map: address 2c returns bits 7:0 of channel c and address 2c+1 returns bits 15:8. Address 10 returns the flags in bits 4:0 (bit c belongs to channel c). Any other address reads 0.
- R3: In pin mode, channels 1 to 3 capture on a rising edge of their pin only. The value stored is timer_i at the first strobed clock edge after the strobed edge whose sample showed the transition.
- R4: Channels 0 and 4 use edge_rise_i[0] and edge_rise_i[1] respectively. A value of 1 selects rising-edge capture and a value of 0 selects falling-edge capture.
- R5: Pins are sampled only on strobed cycles. A transition is two consecutive samples that differ in the selected direction. No transition is recognized until two samples have been taken since reset. Without a strobe or a write, register contents and flags hold.
- R6: A recognized transition on a pin-mode channel sets that channel's flag at the same edge as the capture. A software-mode capture never sets a flag.
- R7: Writing address 10 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A flag-setting event at the same edge wins over the clear.
- R8: In software mode, a write to the low byte arms a capture. The capture takes the timer value at the first strobed edge strictly after the write, and the written data is discarded.
- R9: In software mode, pin transitions have no effect on the register or the flag.
- R10: A high-byte write stores the data in both modes. In pin mode, a low-byte write stores the data. A capture at the same edge overrides a byte write.
- R11: Channels in different modes operate together, each following its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mcyc_en_i | input | 1 | Machine-cycle strobe |
| timer_i | input | 16 | Free-running timer value |
| cap_pin_i | input | 5 | Capture input pins, one per channel |
| mode_sw_i | input | 5 | Per-channel mode: 0 pin, 1 software |
| edge_rise_i | input | 2 | Polarity for channels 0 and 4: 1 rising, 0 falling |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational on address |
| irq_o | output | 5 | Interrupt request flags |

## Verification
A bad sample or primed state shows up as a flag that rises one strobe too early or too late, or rises at all after reset. It also shows up as a captured byte that holds the wrong timer value, and this is visible at the next read of that address. An armed software capture that is lost or that fires twice changes the register contents at the very next strobed edge. The bench compares the read data and the flags against a reference on every clock and sweeps the addresses. Any such error therefore appears within one machine cycle, or by the time the sweep reaches that byte.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {MODE_PIN = 1'b0, MODE_SW = 1'b1} cap_mode_e;

  // number of programmable-polarity channels below channel ch
  function automatic int prog_below(logic [31:0] mask, int ch);
    int n = 0;
    for (int i = 0; i < ch; i++) if (mask[i]) n++;
    return n;
  endfunction

  function automatic int prog_count(logic [31:0] mask, int nch);
    return prog_below(mask, nch);
  endfunction
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_i,
  input  logic primed_i,
  input  logic rise_i,
  output logic edge_o
);
  logic prev_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cur_q  <= 1'b0;
    end else if (en_i) begin
      prev_q <= cur_q;
      cur_q  <= pin_i;
    end
  end

  assign edge_o = primed_i && (rise_i ? (!prev_q && cur_q) : (prev_q && !cur_q));
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int DW = 8,
  localparam int TW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          edge_i,
  input  logic          mode_sw_i,
  input  logic [TW-1:0] timer_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_flag_i,
  input  logic          flag_bit_i,
  input  logic [DW-1:0] wdata_i,
  output logic [TW-1:0] val_o,
  output logic          flag_o
);
  import cap_pkg::*;

  logic pend_q, pin_evt, capture;
  logic [TW-1:0] val_q;
  logic flag_q;

  assign pin_evt = en_i && edge_i && (cap_mode_e'(mode_sw_i) == MODE_PIN);
  assign capture = pin_evt || (en_i && pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (wr_lo_i && mode_sw_i) pend_q <= 1'b1;
    else if (en_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else if (capture) val_q <= timer_i;
    else begin
      if (wr_lo_i && !mode_sw_i) val_q[DW-1:0]  <= wdata_i;
      if (wr_hi_i)               val_q[TW-1:DW] <= wdata_i;
    end
  end

  // set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (pin_evt) flag_q <= 1'b1;
    else if (wr_flag_i && !flag_bit_i) flag_q <= 1'b0;
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
  parameter int          N_CH      = 5,
  parameter int          DW        = 8,
  parameter logic [31:0] PROG_MASK = 32'h0000_0011,
  localparam int TW        = 2 * DW,
  localparam int N_PROG    = cap_pkg::prog_count(PROG_MASK, N_CH),
  localparam int FLAG_ADDR = 2 * N_CH,
  localparam int AW        = $clog2(FLAG_ADDR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mcyc_en_i,
  input  logic [TW-1:0]     timer_i,
  input  logic [N_CH-1:0]   cap_pin_i,
  input  logic [N_CH-1:0]   mode_sw_i,
  input  logic [N_PROG-1:0] edge_rise_i,
  input  logic              bus_wr_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [1:0] nsamp_q;
  logic       primed;
  logic       wr_flag;
  logic [TW-1:0] val [N_CH];

  // two samples needed before an edge can be seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nsamp_q <= '0;
    else if (mcyc_en_i && nsamp_q != 2'd2) nsamp_q <= nsamp_q + 2'd1;
  end
  assign primed  = (nsamp_q == 2'd2);
  assign wr_flag = bus_wr_i && (bus_addr_i == AW'(FLAG_ADDR));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic rise, edge_hit, wr_lo, wr_hi;

    if (PROG_MASK[c]) begin : g_prog
      assign rise = edge_rise_i[cap_pkg::prog_below(PROG_MASK, c)];
    end else begin : g_fixed
      assign rise = 1'b1;
    end

    assign wr_lo = bus_wr_i && (bus_addr_i == AW'(2 * c));
    assign wr_hi = bus_wr_i && (bus_addr_i == AW'(2 * c + 1));

    cap_edge_det u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (mcyc_en_i),
      .pin_i   (cap_pin_i[c]),
      .primed_i(primed),
      .rise_i  (rise),
      .edge_o  (edge_hit)
    );

    cap_channel #(.DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (mcyc_en_i),
      .edge_i    (edge_hit),
      .mode_sw_i (mode_sw_i[c]),
      .timer_i   (timer_i),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wr_flag_i (wr_flag),
      .flag_bit_i(bus_wdata_i[c]),
      .wdata_i   (bus_wdata_i),
      .val_o     (val[c]),
      .flag_o    (irq_o[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr_i == AW'(2 * c))     bus_rdata_o = val[c][DW-1:0];
      if (bus_addr_i == AW'(2 * c + 1)) bus_rdata_o = val[c][TW-1:DW];
    end
    if (bus_addr_i == AW'(FLAG_ADDR)) bus_rdata_o[N_CH-1:0] = irq_o;
  end
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int          N_CH      = 5,
  parameter int          DW        = 8,
  parameter logic [31:0] PROG_MASK = 32'h0000_0011,
  localparam int TW        = 2 * DW,
  localparam int N_PROG    = cap_pkg::prog_count(PROG_MASK, N_CH),
  localparam int FLAG_ADDR = 2 * N_CH,
  localparam int AW        = $clog2(FLAG_ADDR + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mcyc_en_i,
  input logic [TW-1:0]     timer_i,
  input logic [N_CH-1:0]   cap_pin_i,
  input logic [N_CH-1:0]   mode_sw_i,
  input logic [N_PROG-1:0] edge_rise_i,
  input logic              bus_wr_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [DW-1:0]     bus_rdata_o,
  input logic [N_CH-1:0]   irq_o
);
  // R6
  flag_rise_pin_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(irq_o) & ($past(mode_sw_i) | {N_CH{!$past(mcyc_en_i)}})) == '0);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == AW'(FLAG_ADDR) && !mcyc_en_i)
    |=> (irq_o & ~$past(bus_wdata_i[N_CH-1:0])) == '0);

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcyc_en_i && !bus_wr_i) |=> (bus_addr_i != $past(bus_addr_i)) || $stable(bus_rdata_o));

  // R5
  idle_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mcyc_en_i && !bus_wr_i) |=> $stable(irq_o));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i > AW'(FLAG_ADDR)) |-> bus_rdata_o == '0);
endmodule

bind cap_unit cap_unit_chk #(.N_CH(N_CH), .DW(DW), .PROG_MASK(PROG_MASK)) u_chk (.*);

// File: tb/cap_unit_bench.sv
`timescale 1ns/1ps
module cap_unit_bench;
  localparam int N = 5;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic [15:0] timer = 16'h0;
  logic [N-1:0] pin = '0;
  logic [N-1:0] mode = '0;
  logic [1:0] esel = 2'b11;
  logic wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [N-1:0] irq;

  always #2.5 clk = ~clk;

  cap_unit u_cap_unit (
    .clk_i(clk), .rst_ni(rst_ni), .mcyc_en_i(en), .timer_i(timer),
    .cap_pin_i(pin), .mode_sw_i(mode), .edge_rise_i(esel),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  int unsigned m_val [N];
  bit m_flag [N], m_pend [N], m_prev [N], m_cur [N];
  int m_nsamp;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N; c++) begin
        m_val[c] = 0; m_flag[c] = 0; m_pend[c] = 0; m_prev[c] = 0; m_cur[c] = 0;
      end
      m_nsamp = 0;
    end else begin
      bit hit [N];
      for (int c = 0; c < N; c++) begin
        bit rise;
        rise = (c == 0) ? esel[0] : (c == 4) ? esel[1] : 1'b1;
        hit[c] = (m_nsamp >= 2) && (rise ? (!m_prev[c] && m_cur[c]) : (m_prev[c] && !m_cur[c]));
      end
      for (int c = 0; c < N; c++) begin
        bit wlo, whi, take;
        wlo  = wr && addr == 4'(2*c);
        whi  = wr && addr == 4'(2*c+1);
        take = en && (m_pend[c] || (hit[c] && !mode[c]));
        if (take) m_val[c] = timer;
        else begin
          if (wlo && !mode[c]) m_val[c] = (m_val[c] & 32'hff00) | wdata;
          if (whi) m_val[c] = (m_val[c] & 32'h00ff) | (32'(wdata) << 8);
        end
        if (wlo && mode[c]) m_pend[c] = 1;
        else if (en) m_pend[c] = 0;
        if (en && hit[c] && !mode[c]) m_flag[c] = 1;
        else if (wr && addr == 4'd10 && !wdata[c]) m_flag[c] = 0;
      end
      if (en) begin
        for (int c = 0; c < N; c++) begin
          m_prev[c] = m_cur[c]; m_cur[c] = pin[c];
        end
        if (m_nsamp < 2) m_nsamp++;
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    logic [7:0] r = '0;
    if (a < 10) r = a[0] ? 8'(m_val[a/2] >> 8) : 8'(m_val[a/2]);
    else if (a == 10) for (int c = 0; c < N; c++) r[c] = m_flag[c];
    return r;
  endfunction

  int vectors = 0, errors = 0;
  string phase = "R1";

  always @(negedge clk) begin
    logic [N-1:0] ef;
    for (int c = 0; c < N; c++) ef[c] = m_flag[c];
    vectors++;
    if (rdata !== exp_rd(addr)) begin
      errors++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", phase, addr, rdata, exp_rd(addr));
    end
    if (irq !== ef) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", phase, irq, ef);
    end
  end

  int div = 1, tk = 0;
  task automatic tick();
    @(posedge clk); #1;
    wr = 1'b0;
    tk++;
    en = (tk % div) == 0;
    timer = timer + 16'd37;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    tick(); wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) begin tick(); addr = 4'(a); end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired expected=done actual=hung");
    finish_run();
  end

  initial begin
    // R1 reset state and R2 read map
    wait_n(3);
    rst_ni = 1'b1;
    phase = "R1_R2";
    sweep();

    // R3 R5 rising-only on channels 1-3, strobe every 3 cycles
    phase = "R3_R5"; div = 3;
    pin = 5'b01110; wait_n(8); sweep();
    pin = 5'b00000; wait_n(8); sweep();
    pin = 5'b00100; wait_n(2); pin = 5'b00000; wait_n(6); sweep();

    // R4 programmable polarity
    phase = "R4"; div = 1; esel = 2'b00;
    pin = 5'b10001; wait_n(4); pin = 5'b00000; wait_n(4); sweep();
    esel = 2'b11;
    pin = 5'b10001; wait_n(4); pin = 5'b00000; wait_n(4); sweep();

    // R7 clear, keep, and set-beats-clear
    phase = "R7";
    bus_wr(4'd10, 8'b11111110); tick(); addr = 4'd10; wait_n(2);
    bus_wr(4'd10, 8'b00000000); tick(); addr = 4'd10; wait_n(2);
    pin = 5'b00010; tick(); tick();
    wr = 1'b1; addr = 4'd10; wdata = 8'h00;
    wait_n(3); addr = 4'd10; wait_n(2);
    pin = 5'b00000; bus_wr(4'd10, 8'h00); wait_n(2);

    // R8 software capture, data discarded, strobe every 4
    phase = "R8_R6"; div = 4; mode = 5'b11111;
    for (int c = 0; c < N; c++) bus_wr(4'(2*c), 8'hA5);
    wait_n(10); sweep();
    bus_wr(4'd4, 8'h3C); bus_wr(4'd4, 8'hC3); wait_n(10); sweep();

    // R9 pins ignored in software mode
    phase = "R9"; div = 2;
    pin = 5'b11111; wait_n(8); pin = 5'b00000; wait_n(8); sweep();

    // R10 byte writes and capture override
    phase = "R10"; div = 1; mode = 5'b00000;
    bus_wr(4'd0, 8'h12); bus_wr(4'd1, 8'h34); bus_wr(4'd9, 8'h56); bus_wr(4'd8, 8'h78);
    sweep();
    mode = 5'b00100; bus_wr(4'd5, 8'h9A); sweep();
    mode = 5'b00000; pin = 5'b00010; tick();
    wr = 1'b1; addr = 4'd3; wdata = 8'hEE;
    tick(); pin = 5'b00000; wait_n(3); sweep();

    // R11 mixed modes
    phase = "R11"; div = 2; mode = 5'b01010; esel = 2'b01;
    pin = 5'b01111; wait_n(6);
    for (int c = 0; c < N; c++) bus_wr(4'(2*c), 8'h55);
    pin = 5'b10000; wait_n(6); sweep();
    pin = 5'b00000; wait_n(6); sweep();

    finish_run();
  end
endmodule